// File: doc/BRIEF.md
# Interrupt enable/pending delegation unit

This block holds the machine-level interrupt-enable vector and the machine-level interrupt-pending vector of a hart. It also holds the interrupt-delegation and exception-delegation registers. Software reaches this state through a set of views, one per privilege level. Each view presents a masked, and sometimes bit-shifted, picture of the shared vectors.

Every access is a read-modify-write. The requester names a view and supplies a data word and a write mask. It gets back the view's value from before the update, and the update lands on the next clock edge.

Pending bits can be owned by hardware. A claim vector marks those bit positions. On a claimed position the hardware pending input drives the visible pending bit, and software writes to that position are dropped. When virtualization is active, the supervisor views show the virtual-supervisor bits moved down one position into the supervisor slots. The virtual-supervisor group can be removed entirely by parameter.

Top module: `irqd_unit`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, the enable, pending, interrupt-delegation and exception-delegation outputs are all zero.
- R2: View code 0 (machine enable) reads the enable vector. A write stores (old AND NOT mask) OR (data AND mask), limited to bit positions 1,3,5,7,9,11 plus, when the hypervisor group is present, 2,6,10. Writes take effect at the clock edge that samples acc_valid, and acc_rdata always shows the value before that edge.
- R3: View code 8 (interrupt delegation) accepts writes only on supervisor positions 1 (software), 5 (timer) and 9 (external). With the hypervisor group present, positions 2, 6 and 10 read 1 after any write to this view.
- R4: View code 9 (exception delegation) can hold only bits 0 to 13, 15, 20, 21 and 23. Every other bit reads 0.
- R5: View code 1 (machine pending) returns the visible pending vector from before the update. Software may change a bit only where the mask is set, the bit is a supervisor bit (1,5,9) or a virtual-supervisor bit (2,6,10, hypervisor present only), and the bit is not claimed. Machine bits 3, 7 and 11 are set only by hardware.
- R6: The visible pending vector equals the software-held bits OR (hw_pend AND hw_claim). A software write never changes a claimed position.
- R7: View code 2 (supervisor enable) with virtualization off reads enable AND delegation AND supervisor group. A write changes only supervisor-group enable bits that are delegated.
- R8: View code 2 with virtualization on reads (enable AND delegation AND virtual group) shifted right by one. A write shifts the merged value left by one and changes only delegated virtual-group enable bits.
- R9: View code 3 (supervisor pending) with virtualization off reads pending AND delegation AND supervisor group. The write mask is limited to bits 0, 1 and 8 and to delegated bits, so only a delegated bit 1 can change.
- R10: View code 3 with virtualization on shifts data and mask left by one and limits the write to a delegated bit 2. The read returns (pending AND delegation AND bit 2) shifted right by one.
- R11: View code 4 (hypervisor enable) reads and writes only enable bits 2, 6 and 10. View code 5 (hypervisor pending) reads pending AND {2,6,10} and may write only those bits.
- R12: View code 6 (virtual-supervisor enable) reads enable AND delegation AND {2,6,10} and writes only delegated bits of that group. View code 7 (virtual-supervisor pending) reads pending AND delegation AND bit 2 and may write only a delegated bit 2.
- R13: Without the hypervisor group, views 4 to 7 read zero and writes to them have no effect. virt_on is ignored, and no software-held bit 2, 6 or 10 is ever set.
- R14: View codes 10 to 15 read zero and change nothing. When acc_valid is low, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access request; the update happens at this edge |
| acc_view | input | 4 | View code, 0 to 9 |
| acc_wdata | input | XLEN | Write data in the view's bit layout |
| acc_wmask | input | XLEN | Per-bit write mask |
| acc_rdata | output | XLEN | View value from before the update |
| virt_on | input | 1 | Virtualization active; remaps the supervisor views |
| hw_claim | input | XLEN | Pending positions owned by hardware |
| hw_pend | input | XLEN | Hardware pending levels |
| en_vec_o | output | XLEN | Machine enable vector |
| pend_vec_o | output | XLEN | Visible machine pending vector |
| ideleg_o | output | XLEN | Interrupt delegation register |
| edeleg_o | output | XLEN | Exception delegation register |

## Verification
The bench builds two copies of the block at XLEN = 32, side by side and fed the same stimulus. One copy has the virtual-supervisor group and one does not. This brings the shifted supervisor views and the removed-group behaviour within reach in the same run.

The narrow 12-bit interrupt field allows an exhaustive sweep of all 4096 machine-pending write masks against rotating claim patterns. Every single-bit exception-delegation write and every combination of supervisor delegation bits are also covered. A long pseudo-random run then mixes all sixteen view codes, both virtualization states and idle cycles.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

   // view selector carried on acc_view
   typedef enum logic [3:0] {
      VW_MEN    = 4'd0,
      VW_MPEND  = 4'd1,
      VW_SEN    = 4'd2,
      VW_SPEND  = 4'd3,
      VW_HEN    = 4'd4,
      VW_HPEND  = 4'd5,
      VW_VSEN   = 4'd6,
      VW_VSPEND = 4'd7,
      VW_IDELEG = 4'd8,
      VW_EDELEG = 4'd9
   } view_e;

   // interrupt field width and bit positions
   localparam int unsigned IRQ_W  = 12;
   localparam int unsigned B_SSI  = 1;
   localparam int unsigned B_VSSI = 2;
   localparam int unsigned B_MSI  = 3;
   localparam int unsigned B_STI  = 5;
   localparam int unsigned B_VSTI = 6;
   localparam int unsigned B_MTI  = 7;
   localparam int unsigned B_SEI  = 9;
   localparam int unsigned B_VSEI = 10;
   localparam int unsigned B_MEI  = 11;

   // groups of interrupt lines
   localparam logic [IRQ_W-1:0] GRP_S  = IRQ_W'((1 << B_SSI) | (1 << B_STI) | (1 << B_SEI));
   localparam logic [IRQ_W-1:0] GRP_VS = IRQ_W'((1 << B_VSSI) | (1 << B_VSTI) | (1 << B_VSEI));
   localparam logic [IRQ_W-1:0] GRP_M  = IRQ_W'((1 << B_MSI) | (1 << B_MTI) | (1 << B_MEI));
   localparam logic [IRQ_W-1:0] ONE_VSSI = IRQ_W'(1 << B_VSSI);

   // supervisor-pending write filter: bits 0, 1 and 8
   localparam logic [IRQ_W-1:0] SPEND_FILT = IRQ_W'(12'h103);

   // exception causes that may be delegated
   localparam int unsigned EXC_W = 24;
   localparam logic [EXC_W-1:0] EXC_DELEGABLE = 24'hB0_BFFF;

endpackage

// File: rtl/irqd_csr_reg.sv
// Legalising register: keeps only LEGAL bits of a write, then sets FORCE1.
module irqd_csr_reg #(
   parameter int unsigned   XLEN   = 32,
   parameter logic [XLEN-1:0] LEGAL  = '0,
   parameter logic [XLEN-1:0] FORCE1 = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [XLEN-1:0] nxt,
   output logic [XLEN-1:0] q
);

   if (XLEN == 0) begin : g_bad_w
      $error("irqd_csr_reg: XLEN must be non-zero");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (we) begin
         q <= (nxt & LEGAL) | FORCE1;
      end
   end

endmodule

// File: rtl/irqd_pend_reg.sv
// Software-held pending bits with hardware claim override.
module irqd_pend_reg #(
   parameter int unsigned     XLEN   = 32,
   parameter logic [XLEN-1:0] SWABLE = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [XLEN-1:0] wr_mask,
   input  logic [XLEN-1:0] wr_data,
   input  logic [XLEN-1:0] claim,
   input  logic [XLEN-1:0] hw_pend,
   output logic [XLEN-1:0] vis
);

   logic [XLEN-1:0] sw_q;
   logic [XLEN-1:0] eff;

   // software may touch only writable, unclaimed positions
   assign eff = wr_mask & SWABLE & ~claim;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sw_q <= '0;
      end else begin
         sw_q <= (sw_q & ~eff) | (wr_data & eff);
      end
   end

   assign vis = sw_q | (hw_pend & claim);

endmodule

// File: rtl/irqd_view_mux.sv
// Per-view read masking and write steering.
module irqd_view_mux
   import irqd_pkg::*;
#(
   parameter int unsigned XLEN   = 32,
   parameter bit          HYP_EN = 1'b1
) (
   input  logic            valid,
   input  logic [3:0]      view,
   input  logic            virt_on,
   input  logic [XLEN-1:0] wdata,
   input  logic [XLEN-1:0] wmask,
   input  logic [XLEN-1:0] en_q,
   input  logic [XLEN-1:0] pend_q,
   input  logic [XLEN-1:0] ideleg_q,
   input  logic [XLEN-1:0] edeleg_q,
   output logic [XLEN-1:0] rdata,
   output logic            en_we,
   output logic [XLEN-1:0] en_nxt,
   output logic            id_we,
   output logic [XLEN-1:0] id_nxt,
   output logic            ed_we,
   output logic [XLEN-1:0] ed_nxt,
   output logic [XLEN-1:0] pd_mask,
   output logic [XLEN-1:0] pd_data
);

   localparam logic [XLEN-1:0] L_S     = XLEN'(GRP_S);
   localparam logic [XLEN-1:0] L_VS    = XLEN'(GRP_VS);
   localparam logic [XLEN-1:0] L_VSSI  = XLEN'(ONE_VSSI);
   localparam logic [XLEN-1:0] L_SFILT = XLEN'(SPEND_FILT);

   logic            hv;
   logic            virt_eff;
   view_e           vsel;
   logic [XLEN-1:0] merged;
   logic [XLEN-1:0] s_dlg;
   logic [XLEN-1:0] vs_dlg;

   generate
      if (HYP_EN) begin : g_hyp
         assign hv       = 1'b1;
         assign virt_eff = virt_on;
      end else begin : g_nohyp
         assign hv       = 1'b0;
         assign virt_eff = 1'b0;
      end
   endgenerate

   assign vsel   = view_e'(view);
   assign s_dlg  = L_S & ideleg_q;
   assign vs_dlg = L_VS & ideleg_q;

   // read side: value before the update
   always_comb begin
      rdata = '0;
      case (vsel)
         VW_MEN:    rdata = en_q;
         VW_MPEND:  rdata = pend_q;
         VW_SEN:    rdata = virt_eff ? ((en_q & vs_dlg) >> 1) : (en_q & s_dlg);
         VW_SPEND:  rdata = virt_eff ? ((pend_q & ideleg_q & L_VSSI) >> 1)
                                     : (pend_q & s_dlg);
         VW_HEN:    rdata = hv ? (en_q & L_VS) : '0;
         VW_HPEND:  rdata = hv ? (pend_q & L_VS) : '0;
         VW_VSEN:   rdata = hv ? (en_q & vs_dlg) : '0;
         VW_VSPEND: rdata = hv ? (pend_q & ideleg_q & L_VSSI) : '0;
         VW_IDELEG: rdata = ideleg_q;
         VW_EDELEG: rdata = edeleg_q;
         default:   rdata = '0;
      endcase
   end

   assign merged = (rdata & ~wmask) | (wdata & wmask);

   // write side
   always_comb begin
      en_we   = 1'b0;
      en_nxt  = en_q;
      id_we   = 1'b0;
      id_nxt  = ideleg_q;
      ed_we   = 1'b0;
      ed_nxt  = edeleg_q;
      pd_mask = '0;
      pd_data = wdata;
      if (valid) begin
         case (vsel)
            VW_MEN: begin
               en_we  = 1'b1;
               en_nxt = merged;
            end
            VW_MPEND: begin
               pd_mask = wmask;
            end
            VW_SEN: begin
               en_we = 1'b1;
               if (virt_eff) begin
                  en_nxt = (en_q & ~vs_dlg) | ((merged << 1) & vs_dlg);
               end else begin
                  en_nxt = (en_q & ~s_dlg) | (merged & s_dlg);
               end
            end
            VW_SPEND: begin
               if (virt_eff) begin
                  pd_mask = ((wmask & L_SFILT) << 1) & ideleg_q & L_VSSI;
                  pd_data = wdata << 1;
               end else begin
                  pd_mask = wmask & ideleg_q & L_SFILT;
               end
            end
            VW_HEN: begin
               en_we  = hv;
               en_nxt = (en_q & ~L_VS) | (merged & L_VS);
            end
            VW_HPEND: begin
               pd_mask = hv ? (wmask & L_VS) : '0;
            end
            VW_VSEN: begin
               en_we  = hv;
               en_nxt = (en_q & ~vs_dlg) | (merged & vs_dlg);
            end
            VW_VSPEND: begin
               pd_mask = hv ? (wmask & ideleg_q & L_VSSI) : '0;
            end
            VW_IDELEG: begin
               id_we  = 1'b1;
               id_nxt = merged;
            end
            VW_EDELEG: begin
               ed_we  = 1'b1;
               ed_nxt = merged;
            end
            default: begin
               en_we = 1'b0;
            end
         endcase
      end
   end

endmodule

// File: rtl/irqd_unit.sv
// Interrupt enable/pending delegation unit, top level.
module irqd_unit
   import irqd_pkg::*;
#(
   parameter int unsigned XLEN   = 32,
   parameter bit          HYP_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            acc_valid,
   input  logic [3:0]      acc_view,
   input  logic [XLEN-1:0] acc_wdata,
   input  logic [XLEN-1:0] acc_wmask,
   output logic [XLEN-1:0] acc_rdata,
   input  logic            virt_on,
   input  logic [XLEN-1:0] hw_claim,
   input  logic [XLEN-1:0] hw_pend,
   output logic [XLEN-1:0] en_vec_o,
   output logic [XLEN-1:0] pend_vec_o,
   output logic [XLEN-1:0] ideleg_o,
   output logic [XLEN-1:0] edeleg_o
);

   // elaboration-time parameter checks
   if (XLEN < EXC_W || XLEN > 64) begin : g_bad_xlen
      $error("irqd_unit: XLEN must lie between 24 and 64");
   end

   localparam logic [IRQ_W-1:0] VS_OPT = HYP_EN ? GRP_VS : '0;
   localparam logic [XLEN-1:0] EN_LEGAL  = XLEN'(GRP_M | GRP_S | VS_OPT);
   localparam logic [XLEN-1:0] ID_LEGAL  = XLEN'(GRP_S);
   localparam logic [XLEN-1:0] ID_FORCE  = XLEN'(VS_OPT);
   localparam logic [XLEN-1:0] ED_LEGAL  = XLEN'(EXC_DELEGABLE);
   localparam logic [XLEN-1:0] PD_SWABLE = XLEN'(GRP_S | VS_OPT);

   logic            en_we, id_we, ed_we;
   logic [XLEN-1:0] en_nxt, id_nxt, ed_nxt;
   logic [XLEN-1:0] pd_mask, pd_data;
   logic [XLEN-1:0] en_q, id_q, ed_q, pd_vis;

   irqd_view_mux #(.XLEN(XLEN), .HYP_EN(HYP_EN)) u_mux (
      .valid    (acc_valid),
      .view     (acc_view),
      .virt_on  (virt_on),
      .wdata    (acc_wdata),
      .wmask    (acc_wmask),
      .en_q     (en_q),
      .pend_q   (pd_vis),
      .ideleg_q (id_q),
      .edeleg_q (ed_q),
      .rdata    (acc_rdata),
      .en_we    (en_we),
      .en_nxt   (en_nxt),
      .id_we    (id_we),
      .id_nxt   (id_nxt),
      .ed_we    (ed_we),
      .ed_nxt   (ed_nxt),
      .pd_mask  (pd_mask),
      .pd_data  (pd_data)
   );

   irqd_csr_reg #(.XLEN(XLEN), .LEGAL(EN_LEGAL), .FORCE1('0)) u_en (
      .clk (clk), .rst_n (rst_n), .we (en_we), .nxt (en_nxt), .q (en_q)
   );

   irqd_csr_reg #(.XLEN(XLEN), .LEGAL(ID_LEGAL), .FORCE1(ID_FORCE)) u_idel (
      .clk (clk), .rst_n (rst_n), .we (id_we), .nxt (id_nxt), .q (id_q)
   );

   irqd_csr_reg #(.XLEN(XLEN), .LEGAL(ED_LEGAL), .FORCE1('0)) u_edel (
      .clk (clk), .rst_n (rst_n), .we (ed_we), .nxt (ed_nxt), .q (ed_q)
   );

   irqd_pend_reg #(.XLEN(XLEN), .SWABLE(PD_SWABLE)) u_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_mask (pd_mask),
      .wr_data (pd_data),
      .claim   (hw_claim),
      .hw_pend (hw_pend),
      .vis     (pd_vis)
   );

   assign en_vec_o   = en_q;
   assign pend_vec_o = pd_vis;
   assign ideleg_o   = id_q;
   assign edeleg_o   = ed_q;

endmodule

// File: rtl/irqd_unit_chk.sv
module irqd_unit_chk
   import irqd_pkg::*;
#(
   parameter int unsigned XLEN   = 32,
   parameter bit          HYP_EN = 1'b1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            acc_valid,
   input logic [3:0]      acc_view,
   input logic [XLEN-1:0] hw_claim,
   input logic [XLEN-1:0] hw_pend,
   input logic [XLEN-1:0] en_vec_o,
   input logic [XLEN-1:0] pend_vec_o,
   input logic [XLEN-1:0] ideleg_o,
   input logic [XLEN-1:0] edeleg_o
);

   localparam logic [XLEN-1:0] C_S  = XLEN'(GRP_S);
   localparam logic [XLEN-1:0] C_VS = XLEN'(GRP_VS);
   localparam logic [XLEN-1:0] C_M  = XLEN'(GRP_M);
   localparam logic [XLEN-1:0] C_VO = HYP_EN ? C_VS : '0;
   localparam logic [XLEN-1:0] C_EX = XLEN'(EXC_DELEGABLE);

   // R1
   reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (en_vec_o == '0 && ideleg_o == '0 && edeleg_o == '0));

   // R2
   en_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_vec_o & ~(C_M | C_S | C_VO)) == '0);

   // R3
   ideleg_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ideleg_o & ~(C_S | C_VO)) == '0);

   // R4
   edeleg_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (edeleg_o & ~C_EX) == '0);

   // R5
   mbits_hw_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_vec_o & C_M & ~(hw_claim & hw_pend)) == '0);

   // R6
   claim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(hw_claim) && $stable(hw_pend)) |->
         ((pend_vec_o & hw_claim) == ($past(pend_vec_o) & hw_claim)));

   // R14
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> ($stable(en_vec_o) && $stable(ideleg_o) && $stable(edeleg_o)));

   generate
      if (HYP_EN) begin : g_hyp_chk
         // R3
         ideleg_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_valid && acc_view == 4'd8) |=> ((ideleg_o & C_VS) == C_VS));
      end else begin : g_nohyp_chk
         // R13
         vs_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((en_vec_o | ideleg_o) & C_VS) == '0 &&
            (pend_vec_o & C_VS & ~(hw_claim & hw_pend)) == '0);
      end
   endgenerate

endmodule

bind irqd_unit irqd_unit_chk #(.XLEN(XLEN), .HYP_EN(HYP_EN)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .acc_valid  (acc_valid),
   .acc_view   (acc_view),
   .hw_claim   (hw_claim),
   .hw_pend    (hw_pend),
   .en_vec_o   (en_vec_o),
   .pend_vec_o (pend_vec_o),
   .ideleg_o   (ideleg_o),
   .edeleg_o   (edeleg_o)
);

// File: tb/irqd_unit_test.sv
module irqd_unit_test;

   localparam int XW = 32;
   localparam logic [XW-1:0] K_S    = 32'h222;
   localparam logic [XW-1:0] K_VS   = 32'h444;
   localparam logic [XW-1:0] K_M    = 32'h888;
   localparam logic [XW-1:0] K_VSSI = 32'h004;
   localparam logic [XW-1:0] K_SF   = 32'h103;
   localparam logic [XW-1:0] K_EX   = 32'h00B0_BFFF;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic          valid;
   logic [3:0]    view;
   logic          virt;
   logic [XW-1:0] wd, wm, claim, hw;

   logic [XW-1:0] rd [2];
   logic [XW-1:0] en [2];
   logic [XW-1:0] pd [2];
   logic [XW-1:0] id [2];
   logic [XW-1:0] ed [2];

   irqd_unit #(.XLEN(XW), .HYP_EN(1'b1)) uut (
      .clk (clk), .rst_n (rst_n), .acc_valid (valid), .acc_view (view),
      .acc_wdata (wd), .acc_wmask (wm), .acc_rdata (rd[1]), .virt_on (virt),
      .hw_claim (claim), .hw_pend (hw), .en_vec_o (en[1]), .pend_vec_o (pd[1]),
      .ideleg_o (id[1]), .edeleg_o (ed[1])
   );

   irqd_unit #(.XLEN(XW), .HYP_EN(1'b0)) uut_nh (
      .clk (clk), .rst_n (rst_n), .acc_valid (valid), .acc_view (view),
      .acc_wdata (wd), .acc_wmask (wm), .acc_rdata (rd[0]), .virt_on (virt),
      .hw_claim (claim), .hw_pend (hw), .en_vec_o (en[0]), .pend_vec_o (pd[0]),
      .ideleg_o (id[0]), .edeleg_o (ed[0])
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   // model state, index 1 = with hypervisor group, 0 = without
   logic [XW-1:0] m_en [2];
   logic [XW-1:0] m_sw [2];
   logic [XW-1:0] m_id [2];
   logic [XW-1:0] m_ed [2];

   task automatic chk(string req, string what, logic [XW-1:0] act, logic [XW-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [XW-1:0] m_vis(int h);
      return m_sw[h] | (hw & claim);
   endfunction

   function automatic logic [XW-1:0] m_read(int h);
      logic ve;
      ve = virt & (h == 1);
      case (view)
         4'd0: return m_en[h];
         4'd1: return m_vis(h);
         4'd2: return ve ? ((m_en[h] & m_id[h] & K_VS) >> 1) : (m_en[h] & m_id[h] & K_S);
         4'd3: return ve ? ((m_vis(h) & m_id[h] & K_VSSI) >> 1) : (m_vis(h) & m_id[h] & K_S);
         4'd4: return (h == 1) ? (m_en[h] & K_VS) : '0;
         4'd5: return (h == 1) ? (m_vis(h) & K_VS) : '0;
         4'd6: return (h == 1) ? (m_en[h] & m_id[h] & K_VS) : '0;
         4'd7: return (h == 1) ? (m_vis(h) & m_id[h] & K_VSSI) : '0;
         4'd8: return m_id[h];
         4'd9: return m_ed[h];
         default: return '0;
      endcase
   endfunction

   function automatic string req_of(int h);
      if (!valid || view > 4'd9) return "R14";
      if (h == 0 && view >= 4'd4 && view <= 4'd7) return "R13";
      case (view)
         4'd0: return "R2";
         4'd1: return "R5";
         4'd2: return (virt && h == 1) ? "R8" : "R7";
         4'd3: return (virt && h == 1) ? "R10" : "R9";
         4'd4, 4'd5: return "R11";
         4'd6, 4'd7: return "R12";
         4'd8: return "R3";
         default: return "R4";
      endcase
   endfunction

   task automatic m_write(int h);
      logic [XW-1:0] mg, pm, pdat, eff, vd, sd, sw_ok;
      logic ve;
      ve    = virt & (h == 1);
      mg    = (m_read(h) & ~wm) | (wd & wm);
      vd    = K_VS & m_id[h];
      sd    = K_S & m_id[h];
      pm    = '0;
      pdat  = wd;
      sw_ok = (h == 1) ? (K_S | K_VS) : K_S;
      if (valid) begin
         case (view)
            4'd0: m_en[h] = mg & ((h == 1) ? (K_M | K_S | K_VS) : (K_M | K_S));
            4'd1: pm = wm;
            4'd2: m_en[h] = ve ? ((m_en[h] & ~vd) | ((mg << 1) & vd))
                               : ((m_en[h] & ~sd) | (mg & sd));
            4'd3: begin
               if (ve) begin
                  pm   = ((wm & K_SF) << 1) & m_id[h] & K_VSSI;
                  pdat = wd << 1;
               end else begin
                  pm = wm & m_id[h] & K_SF;
               end
            end
            4'd4: if (h == 1) m_en[h] = (m_en[h] & ~K_VS) | (mg & K_VS);
            4'd5: if (h == 1) pm = wm & K_VS;
            4'd6: if (h == 1) m_en[h] = (m_en[h] & ~vd) | (mg & vd);
            4'd7: if (h == 1) pm = wm & m_id[h] & K_VSSI;
            4'd8: m_id[h] = (mg & K_S) | ((h == 1) ? K_VS : '0);
            4'd9: m_ed[h] = mg & K_EX;
            default: pm = '0;
         endcase
      end
      eff     = pm & sw_ok & ~claim;
      m_sw[h] = (m_sw[h] & ~eff) | (pdat & eff);
   endtask

   task automatic check_outs(string req);
      for (int h = 0; h < 2; h++) begin
         chk(req, "enable", en[h], m_en[h]);
         chk(req, "pending", pd[h], m_vis(h));
         chk(req, "ideleg", id[h], m_id[h]);
         chk(req, "edeleg", ed[h], m_ed[h]);
      end
   endtask

   task automatic step(logic v, logic [3:0] vw, logic vt, logic [XW-1:0] dat,
                       logic [XW-1:0] msk, logic [XW-1:0] cl, logic [XW-1:0] hp, string freq);
      string tag;
      @(negedge clk);
      valid = v; view = vw; virt = vt; wd = dat; wm = msk; claim = cl; hw = hp;
      #1;
      for (int h = 0; h < 2; h++) begin
         tag = (freq != "") ? freq : req_of(h);
         chk(tag, "read", rd[h], m_read(h));
         m_write(h);
      end
      @(posedge clk);
      #1;
      check_outs((freq != "") ? freq : req_of(1));
   endtask

   function automatic logic [31:0] nx(logic [31:0] s);
      logic [31:0] t;
      t = s ^ (s << 13);
      t = t ^ (t >> 17);
      t = t ^ (t << 5);
      return t;
   endfunction

   initial begin
      #(8 * 150000);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      valid = 1'b0; view = 4'd0; virt = 1'b0; wd = '0; wm = '0; claim = '0; hw = '0;
      for (int h = 0; h < 2; h++) begin
         m_en[h] = '0; m_sw[h] = '0; m_id[h] = '0; m_ed[h] = '0;
      end
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      check_outs("R1");
      for (int h = 0; h < 2; h++) chk("R1", "read", rd[h], '0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check_outs("R1");

      // R3 every supervisor delegation combination
      for (int s = 0; s < 8; s++) begin
         step(1'b1, 4'd8, 1'b0, ~32'h0 & ~(32'(s[0]) << 1 ^ 32'h2) & ~(32'(s[1]) << 5 ^ 32'h20)
              & ~(32'(s[2]) << 9 ^ 32'h200), ~32'h0, '0, '0, "R3");
      end
      // R4 each single exception-delegation bit
      for (int b = 0; b < 32; b++) begin
         step(1'b1, 4'd9, 1'b0, 32'h1 << b, 32'h1 << b, '0, '0, "R4");
      end
      step(1'b1, 4'd9, 1'b0, '0, ~32'h0, '0, '0, "R4");

      // mixed pseudo-random run across all views
      r = 32'h1234_5678;
      for (int it = 0; it < 3000; it++) begin
         logic [31:0] a, b, c, d;
         r = nx(r); a = r;
         r = nx(r); b = r;
         r = nx(r); c = r;
         r = nx(r); d = r;
         step(a[7:5] != 3'd0, a[3:0], a[4], b, (a[8] ? ~32'h0 : c),
              (a[9] ? (d & 32'hEEE) : '0), c ^ d, "");
      end

      // R5 / R6 exhaustive machine-pending masks with rotating claims
      for (int m = 0; m < 4096; m++) begin
         logic [XW-1:0] cl;
         cl = (32'hEEE >> (m % 5)) & 32'hEEE & ((m % 3 == 0) ? 32'h0 : ~32'h0);
         step(1'b1, 4'd1, 1'b0, 32'(m) ^ 32'hA5A, 32'(m), cl, 32'(m * 7), (cl == '0) ? "R5" : "R6");
      end

      // R10 directed: virtual supervisor software pending through the supervisor view
      step(1'b1, 4'd8, 1'b0, ~32'h0, ~32'h0, '0, '0, "R3");
      step(1'b1, 4'd3, 1'b1, 32'h2, 32'h2, '0, '0, "R10");
      step(1'b0, 4'd3, 1'b1, '0, '0, '0, '0, "R10");
      // R8 directed: supervisor enable under virtualization
      step(1'b1, 4'd2, 1'b1, 32'h222, 32'hFFF, '0, '0, "R8");
      step(1'b0, 4'd4, 1'b0, '0, '0, '0, '0, "R11");
      // R14 unused view codes
      for (int v = 10; v < 16; v++) begin
         step(1'b1, 4'(v), 1'b0, ~32'h0, ~32'h0, '0, '0, "R14");
      end

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule